// File: doc/BRIEF.md
# Daisy-Chained Interrupt Priority Resolver

This block chooses one interrupt to take out of a fixed set of request sources, by default 22. Each source supplies a pending bit and a priority level that software sets. The sources sit in a serial chain of comparators. A running level starts at zero at the head of the chain. At each stage the stage's own level replaces the running level only when that source is requesting and its level is strictly higher. Because of this rule, a tie is always won by the source nearest the head of the chain, which is index 0.

The processor starts a detection pass with a one-cycle-sampled op-code fetch strobe. On that edge the block takes a snapshot of every request bit, every level, the processor priority level and the interrupt-disable flag. It then walks through a fixed sequence of states:

- `ST_IDLE` waits for the strobe. The transition `start` goes to `ST_SCAN`.
- `ST_SCAN` registers the chain result. The transition `scanned` goes to `ST_GATE`.
- `ST_GATE` registers the accept decision. The transition `judged` goes to `ST_ALIGN`.
- `ST_ALIGN` pads the pass to its fixed length. The transition `aligned` goes to `ST_ISSUE`.
- `ST_ISSUE` presents the outcome for one cycle. The transition `retire` goes back to `ST_IDLE`.

A strobe seen in any state other than `ST_IDLE` is ignored. When the pass accepts, the winning source gets a one-cycle acknowledge so that it can clear its own pending bit. A request that is refused is not touched, and it competes again in the next pass.

Top module: `irq_resolver`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `accept_o` is 0 and `ack_o` is all zero. After reset the block is idle, so a strobe on the first cycle starts a pass.
- R2: A pass starts only when `fetch_i` is high at a clock edge while the block is idle. `accept_o` can be high only on the fourth cycle after that edge, and only for one cycle. It is 0 on the three cycles in between.
- R3: The result depends only on the request bits, levels, `ipl_i` and `irq_dis_i` captured at the starting edge. Changes to these inputs later in the pass have no effect on the result.
- R4: A `fetch_i` strobe that arrives while a pass is running, including its issue cycle, does not start a second pass. No further accept appears once the pass ends.
- R5: The winner is the requesting source with the highest level. A source whose request bit is 0 is skipped, whatever its level. Source i's level is `lvl_i[3*i+2:3*i]`.
- R6: Among requesting sources that share the highest level, the lowest index wins.
- R7: A source at level 0 is never accepted. A pass in which no source is requesting produces no accept.
- R8: A pass accepts only if the winning level is strictly greater than the captured `ipl_i` and the captured `irq_dis_i` is 0.
- R9: On an accept, `win_idx_o` and `win_lvl_o` give the winner and `ack_o` has exactly one bit set, at the winner's index. When there is no accept, `ack_o`, `win_idx_o` and `win_lvl_o` are all 0.
- R10: A refused pass keeps no state against its sources. A later pass with the same requests and a permitting `ipl_i` or `irq_dis_i` accepts the same winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fetch_i | input | 1 | Op-code fetch strobe that starts a pass |
| req_i | input | NUM_SRC | Pending bit per source |
| lvl_i | input | NUM_SRC*LVL_W | Priority level per source, packed, source 0 in the low bits |
| ipl_i | input | LVL_W | Processor priority level |
| irq_dis_i | input | 1 | Interrupt-disable flag, 1 blocks acceptance |
| accept_o | output | 1 | One-cycle pulse: interrupt taken |
| win_idx_o | output | IDX_W | Index of the accepted source |
| win_lvl_o | output | LVL_W | Level of the accepted source |
| ack_o | output | NUM_SRC | One-hot acknowledge to the accepted source |

## Verification
The embedded properties assume the following about the inputs:

- Reset is held for at least one edge before any strobe.
- `fetch_i` is never unknown.
- The four-cycle latency property assumes that no pass can complete in fewer cycles than have passed since reset.

The bench meets these assumptions as follows:

- It holds reset for several cycles.
- It changes every input only at falling edges.
- During a pass it deliberately scrambles the request, level, priority and disable inputs and re-raises the strobe, to show that the snapshot and the busy guard hold.

// File: rtl/irq_resolver_pkg.sv
package irq_resolver_pkg;

    parameter int unsigned DEF_NUM_SRC = 22;
    parameter int unsigned DEF_LVL_W   = 3;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SCAN  = 3'd1,
        ST_GATE  = 3'd2,
        ST_ALIGN = 3'd3,
        ST_ISSUE = 3'd4
    } pass_state_e;

endpackage

// File: rtl/irq_chain_stage.sv
module irq_chain_stage #(
    parameter int unsigned LVL_W   = 3,
    parameter int unsigned IDX_W   = 5,
    parameter int unsigned SRC_IDX = 0
) (
    input  logic [LVL_W-1:0] up_lvl,
    input  logic [IDX_W-1:0] up_idx,
    input  logic             src_req,
    input  logic [LVL_W-1:0] src_lvl,
    output logic [LVL_W-1:0] dn_lvl,
    output logic [IDX_W-1:0] dn_idx
);

    localparam logic [IDX_W-1:0] OWN_IDX = IDX_W'(SRC_IDX);

    logic take_own;

    // Upstream value survives ties; only a strictly higher requesting level replaces it.
    always_comb begin
        take_own = src_req && (up_lvl < src_lvl);
        dn_lvl   = take_own ? src_lvl : up_lvl;
        dn_idx   = take_own ? OWN_IDX : up_idx;
    end

endmodule

// File: rtl/irq_chain.sv
module irq_chain #(
    parameter int unsigned NUM_SRC = 22,
    parameter int unsigned LVL_W   = 3,
    parameter int unsigned IDX_W   = 5
) (
    input  logic [NUM_SRC-1:0]       req,
    input  logic [NUM_SRC*LVL_W-1:0] lvl,
    output logic [LVL_W-1:0]         best_lvl,
    output logic [IDX_W-1:0]         best_idx
);

    logic [LVL_W-1:0] lvl_link [NUM_SRC+1];
    logic [IDX_W-1:0] idx_link [NUM_SRC+1];

    assign lvl_link[0] = '0;
    assign idx_link[0] = '0;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_stage
        irq_chain_stage #(
            .LVL_W   (LVL_W),
            .IDX_W   (IDX_W),
            .SRC_IDX (s)
        ) u_stage (
            .up_lvl  (lvl_link[s]),
            .up_idx  (idx_link[s]),
            .src_req (req[s]),
            .src_lvl (lvl[s*LVL_W +: LVL_W]),
            .dn_lvl  (lvl_link[s+1]),
            .dn_idx  (idx_link[s+1])
        );
    end

    assign best_lvl = lvl_link[NUM_SRC];
    assign best_idx = idx_link[NUM_SRC];

endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
    import irq_resolver_pkg::*;
#(
    parameter int unsigned NUM_SRC = DEF_NUM_SRC,
    parameter int unsigned LVL_W   = DEF_LVL_W,
    localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     fetch_i,
    input  logic [NUM_SRC-1:0]       req_i,
    input  logic [NUM_SRC*LVL_W-1:0] lvl_i,
    input  logic [LVL_W-1:0]         ipl_i,
    input  logic                     irq_dis_i,
    output logic                     accept_o,
    output logic [IDX_W-1:0]         win_idx_o,
    output logic [LVL_W-1:0]         win_lvl_o,
    output logic [NUM_SRC-1:0]       ack_o
);

    pass_state_e state_q, state_d;

    logic [NUM_SRC-1:0]       snap_req;
    logic [NUM_SRC*LVL_W-1:0] snap_lvl;
    logic [LVL_W-1:0]         snap_ipl;
    logic                     snap_dis;
    logic [LVL_W-1:0]         scan_lvl, res_lvl;
    logic [IDX_W-1:0]         scan_idx, res_idx;
    logic                     grant_q;
    logic                     start;

    assign start = (state_q == ST_IDLE) && fetch_i;

    irq_chain #(
        .NUM_SRC (NUM_SRC),
        .LVL_W   (LVL_W),
        .IDX_W   (IDX_W)
    ) u_chain (
        .req      (snap_req),
        .lvl      (snap_lvl),
        .best_lvl (scan_lvl),
        .best_idx (scan_idx)
    );

    // Next-state logic: strobes outside IDLE fall through untouched.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (fetch_i) state_d = ST_SCAN;
            ST_SCAN:  state_d = ST_GATE;
            ST_GATE:  state_d = ST_ALIGN;
            ST_ALIGN: state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Snapshot, chain result and accept decision registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            snap_req <= '0;
            snap_lvl <= '0;
            snap_ipl <= '0;
            snap_dis <= 1'b1;
            res_lvl  <= '0;
            res_idx  <= '0;
            grant_q  <= 1'b0;
        end else begin
            if (start) begin
                snap_req <= req_i;
                snap_lvl <= lvl_i;
                snap_ipl <= ipl_i;
                snap_dis <= irq_dis_i;
            end
            if (state_q == ST_SCAN) begin
                res_lvl <= scan_lvl;
                res_idx <= scan_idx;
            end
            if (state_q == ST_GATE) begin
                grant_q <= (res_lvl > snap_ipl) && !snap_dis;
            end
        end
    end

    // Outputs: everything quiet unless the issue cycle carries a grant.
    always_comb begin
        accept_o  = (state_q == ST_ISSUE) && grant_q;
        win_idx_o = '0;
        win_lvl_o = '0;
        ack_o     = '0;
        if (accept_o) begin
            win_idx_o        = res_idx;
            win_lvl_o        = res_lvl;
            ack_o[res_idx]   = 1'b1;
        end
    end

    AST_ACCEPT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        accept_o |=> !accept_o);  // R2
    AST_PASS_LATENCY: assert property (@(posedge clk) disable iff (rst)
        accept_o |-> ($past(fetch_i, 4) && ($past(state_q, 4) == ST_IDLE)));  // R2
    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && $past(state_q) != ST_IDLE) |-> ($stable(snap_req) && $stable(snap_lvl)));  // R3
    AST_WIN_REQUESTED: assert property (@(posedge clk) disable iff (rst)
        accept_o |-> snap_req[win_idx_o]);  // R5
    AST_NONZERO_WIN: assert property (@(posedge clk) disable iff (rst)
        accept_o |-> (win_lvl_o != '0));  // R7
    AST_GRANT_RULE: assert property (@(posedge clk) disable iff (rst)
        accept_o |-> ((win_lvl_o > snap_ipl) && !snap_dis));  // R8
    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        accept_o |-> (ack_o == (NUM_SRC'(1) << win_idx_o)));  // R9
    AST_ACK_QUIET: assert property (@(posedge clk) disable iff (rst)
        !accept_o |-> (ack_o == '0));  // R9

endmodule

// File: tb/irq_resolver_bench.sv
module irq_resolver_bench;

    localparam int N      = 22;
    localparam int LW     = 3;
    localparam int IW     = 5;
    localparam int CLK_NS = 10;
    localparam int SEED   = 32'h5eed_0417;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fetch_i = 1'b0;
    logic [N-1:0]  req_i = '0;
    logic [N*LW-1:0] lvl_i = '0;
    logic [LW-1:0] ipl_i = '0;
    logic          irq_dis_i = 1'b0;
    logic          accept_o;
    logic [IW-1:0] win_idx_o;
    logic [LW-1:0] win_lvl_o;
    logic [N-1:0]  ack_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    irq_resolver u_irq_resolver (
        .clk       (clk),
        .rst       (rst),
        .fetch_i   (fetch_i),
        .req_i     (req_i),
        .lvl_i     (lvl_i),
        .ipl_i     (ipl_i),
        .irq_dis_i (irq_dis_i),
        .accept_o  (accept_o),
        .win_idx_o (win_idx_o),
        .win_lvl_o (win_lvl_o),
        .ack_o     (ack_o)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Highest requesting level, earliest index on ties; packed as level*256+index.
    function automatic int best_of(input logic [N-1:0] rq, input logic [N*LW-1:0] lv);
        int bl = 0;
        int bi = 0;
        for (int i = 0; i < N; i++) begin
            if (rq[i] && int'(lv[i*LW +: LW]) > bl) begin
                bl = int'(lv[i*LW +: LW]);
                bi = i;
            end
        end
        return bl * 256 + bi;
    endfunction

    task automatic run_pass(input logic [N-1:0] rq, input logic [N*LW-1:0] lv,
                            input logic [LW-1:0] ipl, input logic dis, input string tag);
        int b  = best_of(rq, lv);
        int bl = b / 256;
        int bi = b % 256;
        bit ok = (bl > 0) && (bl > int'(ipl)) && !dis;
        @(negedge clk);
        req_i = rq; lvl_i = lv; ipl_i = ipl; irq_dis_i = dis; fetch_i = 1'b1;
        @(posedge clk);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R2", "accept quiet mid-pass", int'(accept_o), 0);
            // R3/R4: scramble inputs and re-strobe while busy
            req_i = {$urandom, $urandom}; lvl_i = {$urandom, $urandom, $urandom};
            ipl_i = LW'($urandom); irq_dis_i = 1'($urandom); fetch_i = 1'($urandom);
            @(posedge clk);
        end
        @(negedge clk);
        check(tag, "accept", int'(accept_o), int'(ok));
        check(tag, "win index", int'(win_idx_o), ok ? bi : 0);
        check(tag, "win level", int'(win_lvl_o), ok ? bl : 0);
        check("R9", "ack vector", int'(ack_o), ok ? (1 << bi) : 0);
        fetch_i = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(posedge clk);
            @(negedge clk);
            check("R4", "no second pass", int'(accept_o), 0);
        end
    endtask

    function automatic logic [N*LW-1:0] all_lvl(input int v);
        logic [N*LW-1:0] r = '0;
        for (int i = 0; i < N; i++) r[i*LW +: LW] = LW'(v);
        return r;
    endfunction

    initial begin
        logic [N*LW-1:0] lv;
        logic [N-1:0] rq;
        void'($urandom(SEED));
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R1", "accept in reset", int'(accept_o), 0);
        check("R1", "ack in reset", int'(ack_o), 0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1", "accept after reset", int'(accept_o), 0);
        check("R1", "ack after reset", int'(ack_o), 0);

        // R1: strobe straight after reset; R5 single top source
        lv = '0; lv[21*LW +: LW] = 3'd7;
        run_pass(22'h200000, lv, 3'd2, 1'b0, "R5");
        run_pass('0, all_lvl(7), 3'd0, 1'b0, "R7");             // nothing requested
        run_pass('1, all_lvl(5), 3'd0, 1'b0, "R6");             // full tie -> index 0
        lv = all_lvl(2); lv[7*LW +: LW] = 3'd4; lv[15*LW +: LW] = 3'd4;
        run_pass('1, lv, 3'd1, 1'b0, "R6");                     // tie at 7 and 15 -> 7
        lv = all_lvl(6); lv[3*LW +: LW] = 3'd1;
        run_pass(22'h000008, lv, 3'd0, 1'b0, "R5");             // unrequested high levels skipped
        lv = '0;
        run_pass(22'h000400, lv, 3'd0, 1'b0, "R7");             // level 0 requester
        lv = '0; lv[9*LW +: LW] = 3'd3;
        run_pass(22'h000200, lv, 3'd3, 1'b0, "R8");             // equal to ipl -> refused
        run_pass(22'h000200, lv, 3'd2, 1'b0, "R8");             // one above -> taken
        run_pass(22'h000200, lv, 3'd0, 1'b1, "R8");             // disabled
        run_pass(22'h000200, lv, 3'd0, 1'b0, "R10");            // same request retried

        for (int n = 0; n < 300; n++) begin
            rq = {$urandom, $urandom};
            if (($urandom % 4) == 0) rq = rq & {$urandom, $urandom};
            lv = {$urandom, $urandom, $urandom};
            run_pass(rq, lv, LW'($urandom), ($urandom % 4) == 0, "R3");
        end

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule